// File: doc/BRIEF.md
# Processor Register File with Per-Code Access Policy

This block holds the architectural registers of a 32-bit processor core. There are sixteen general registers and four writable special registers: an accumulator, a stack pointer, a base pointer and a return-address register. Alongside them sit four more views that are not ordinary storage. One reads as zero. One shows the current program counter, which is supplied on an input. Two are reachable only in kernel mode. A final range of codes marks "no register".

Two independent read ports and one write port each take a 5-bit register code. Every code carries its own access rule. A read or write that breaks its rule raises a combinational fault flag in the same cycle and has no effect on storage. The write port also performs the two halves of a split 32-bit constant load. The low-half form zero-fills the top bits. The high-half form keeps the existing bottom bits.

Top module: `regfile_special`

## Requirements
- R1: Codes 0-15 (general), 16 (accumulator), 17 (stack pointer), 18 (base pointer) and 19 (return address) store a written value. Both read ports return it from the cycle after the write edge.
- R2: Code 20 always reads as 0. A write to it is dropped and does not raise the fault.
- R3: Code 21 reads the current value of `pc_i`. A write to it raises the fault and changes no register.
- R4: Codes 22 and 23 are privileged. With `kernel_i`=1 they read and write like R1. With `kernel_i`=0 an enabled read returns 0 and faults, and a write faults and is ignored.
- R5: Codes 24-31 are the "no register" code. An enabled read returns 0 and faults, and a write faults and changes no register.
- R6: `wr_mode`=01 (low immediate) stores `{16'h0, wr_data[15:0]}`.
- R7: `wr_mode`=10 (high immediate) stores `{wr_data[15:0], old[15:0]}`, which keeps the previous low half.
- R8: `wr_mode`=00 and `wr_mode`=11 store all 32 bits of `wr_data`.
- R9: `fault_o` is combinational. It is high only in a cycle that has an offending enabled read or a write with `wr_en`=1. Codes read with their enable low never fault.
- R10: A read in the same cycle as a write to the same code returns the value held before that write. There is no bypass.
- R11: Reset (`rst_n`=0) clears every stored register, including the privileged ones, to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kernel_i | input | 1 | 1 = kernel mode |
| pc_i | input | 32 | Current program counter, shown at code 21 |
| ra_en | input | 1 | Read port A is in use |
| ra_addr | input | 5 | Read port A code |
| ra_data | output | 32 | Read port A data |
| rb_en | input | 1 | Read port B is in use |
| rb_addr | input | 5 | Read port B code |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write request |
| wr_addr | input | 5 | Write code |
| wr_mode | input | 2 | 00/11 full, 01 low immediate, 10 high immediate |
| wr_data | input | 32 | Write data; the immediate forms use bits 15:0 |
| fault_o | output | 1 | Access violation in this cycle |

## Verification
Two functions meet in one cycle when a read and a write target the same code. The bench forces this by putting the write code on read port A before the edge. It then requires the old value before the edge and the new value after it. A second overlap arises when a legal read and an illegal write share one cycle. That case is judged at `fault_o` and by reading back every code to confirm nothing changed. Full sweeps over all 32 codes in both modes compare every port against a model computed in the bench.

// File: rtl/regfile_special.sv
module regfile_special #(
  parameter int XLEN = 32,
  parameter int NGEN = 16,
  parameter int AW   = $clog2(NGEN + 9)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            kernel_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic            ra_en,
  input  logic [AW-1:0]   ra_addr,
  output logic [XLEN-1:0] ra_data,
  input  logic            rb_en,
  input  logic [AW-1:0]   rb_addr,
  output logic [XLEN-1:0] rb_data,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [1:0]      wr_mode,
  input  logic [XLEN-1:0] wr_data,
  output logic            fault_o
);
  localparam int HALF   = XLEN / 2;
  localparam int NSTORE = NGEN + 4;
  localparam logic [AW-1:0] C_ZERO = AW'(NGEN + 4);
  localparam logic [AW-1:0] C_PC   = AW'(NGEN + 5);
  localparam logic [AW-1:0] C_IDT  = AW'(NGEN + 6);
  localparam logic [AW-1:0] C_MMAP = AW'(NGEN + 7);
  localparam logic [AW-1:0] C_NONE = AW'(NGEN + 8);

  logic [XLEN-1:0] gpr [NSTORE];
  logic [XLEN-1:0] idt_q, mmap_q;
  logic [XLEN-1:0] wr_old, wr_val;
  logic            wr_priv, wr_bad, wr_take;

  function automatic logic is_priv(input logic [AW-1:0] c);
    return (c == C_IDT) || (c == C_MMAP);
  endfunction

  function automatic logic rd_bad(input logic [AW-1:0] c, input logic k);
    return (c >= C_NONE) || (is_priv(c) && !k);
  endfunction

  function automatic logic [XLEN-1:0] rd_val(input logic [AW-1:0] c, input logic k);
    logic [XLEN-1:0] v;
    v = '0;
    if (c < C_ZERO)               v = gpr[c[AW-1:0]];
    else if (c == C_PC)           v = pc_i;
    else if (c == C_IDT  && k)    v = idt_q;
    else if (c == C_MMAP && k)    v = mmap_q;
    return v;
  endfunction

  assign ra_data = rd_val(ra_addr, kernel_i);
  assign rb_data = rd_val(rb_addr, kernel_i);

  assign wr_priv = is_priv(wr_addr);
  assign wr_bad  = wr_en && ((wr_addr == C_PC) || (wr_addr >= C_NONE) || (wr_priv && !kernel_i));
  assign wr_take = wr_en && !wr_bad && (wr_addr != C_ZERO);

  assign fault_o = wr_bad || (ra_en && rd_bad(ra_addr, kernel_i))
                          || (rb_en && rd_bad(rb_addr, kernel_i));

  always_comb begin
    wr_old = '0;
    if (wr_addr < C_ZERO)       wr_old = gpr[wr_addr];
    else if (wr_addr == C_IDT)  wr_old = idt_q;
    else if (wr_addr == C_MMAP) wr_old = mmap_q;
  end

  always_comb begin
    case (wr_mode)
      2'b01:   wr_val = {{(XLEN-HALF){1'b0}}, wr_data[HALF-1:0]};
      2'b10:   wr_val = {wr_data[XLEN-HALF-1:0], wr_old[HALF-1:0]};
      default: wr_val = wr_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSTORE; i++) gpr[i] <= '0;
      idt_q  <= '0;
      mmap_q <= '0;
    end else if (wr_take) begin
      if (wr_addr < C_ZERO)       gpr[wr_addr] <= wr_val;
      else if (wr_addr == C_IDT)  idt_q  <= wr_val;
      else if (wr_addr == C_MMAP) mmap_q <= wr_val;
    end
  end
endmodule

module regfile_special_chk #(
  parameter int XLEN = 32,
  parameter int NGEN = 16,
  parameter int AW   = $clog2(NGEN + 9)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            kernel_i,
  input logic [XLEN-1:0] pc_i,
  input logic            ra_en,
  input logic [AW-1:0]   ra_addr,
  input logic [XLEN-1:0] ra_data,
  input logic            rb_en,
  input logic [AW-1:0]   rb_addr,
  input logic [XLEN-1:0] rb_data,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [1:0]      wr_mode,
  input logic [XLEN-1:0] wr_data,
  input logic            fault_o
);
  localparam logic [AW-1:0] C_ZERO = AW'(NGEN + 4);
  localparam logic [AW-1:0] C_PC   = AW'(NGEN + 5);
  localparam logic [AW-1:0] C_IDT  = AW'(NGEN + 6);
  localparam logic [AW-1:0] C_MMAP = AW'(NGEN + 7);
  localparam logic [AW-1:0] C_NONE = AW'(NGEN + 8);

  a_r2_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_addr == C_ZERO) |-> (ra_data == '0));

  a_r3_pc_view: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_addr == C_PC) |-> (rb_data == pc_i));

  a_r3_pc_write_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == C_PC) |-> fault_o);

  a_r4_user_priv_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_en && !kernel_i && (ra_addr == C_IDT || ra_addr == C_MMAP)) |-> (fault_o && ra_data == '0));

  a_r5_none_faults: assert property (@(posedge clk) disable iff (!rst_n)
    ((ra_en && ra_addr >= C_NONE) || (wr_en && wr_addr >= C_NONE)) |-> fault_o);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ra_en && !rb_en && !wr_en) |-> !fault_o);

  a_r6_low_imm: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en && wr_mode == 2'b01 && wr_addr < C_ZERO)
      && ra_addr == $past(wr_addr)) |-> (ra_data == {16'h0, $past(wr_data[15:0])}));

  a_r7_high_imm: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en && wr_mode == 2'b10 && wr_addr < C_ZERO && rb_addr == wr_addr)
      && ra_addr == $past(wr_addr)) |-> (ra_data == {$past(wr_data[15:0]), $past(rb_data[15:0])}));
endmodule

bind regfile_special regfile_special_chk #(.XLEN(XLEN), .NGEN(NGEN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .kernel_i(kernel_i), .pc_i(pc_i),
  .ra_en(ra_en), .ra_addr(ra_addr), .ra_data(ra_data),
  .rb_en(rb_en), .rb_addr(rb_addr), .rb_data(rb_data),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_mode(wr_mode), .wr_data(wr_data),
  .fault_o(fault_o)
);

// File: tb/regfile_special_tb.sv
`timescale 1ns/1ps
module regfile_special_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        kernel_i = 1'b1;
  logic [31:0] pc_i = 32'h0000_1000;
  logic        ra_en = 1'b0, rb_en = 1'b0, wr_en = 1'b0;
  logic [4:0]  ra_addr = '0, rb_addr = '0, wr_addr = '0;
  logic [1:0]  wr_mode = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] ra_data, rb_data;
  logic        fault_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m [32];

  always #2.5 clk = ~clk;

  regfile_special u_dut (
    .clk(clk), .rst_n(rst_n), .kernel_i(kernel_i), .pc_i(pc_i),
    .ra_en(ra_en), .ra_addr(ra_addr), .ra_data(ra_data),
    .rb_en(rb_en), .rb_addr(rb_addr), .rb_data(rb_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_mode(wr_mode), .wr_data(wr_data),
    .fault_o(fault_o)
  );

  task automatic ck(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic is_priv(input int c);
    return c == 22 || c == 23;
  endfunction

  function automatic logic rfault(input int c, input logic k);
    return c >= 24 || (is_priv(c) && !k);
  endfunction

  function automatic logic wfault(input int c, input logic k);
    return c == 21 || c >= 24 || (is_priv(c) && !k);
  endfunction

  function automatic logic [31:0] mread(input int c, input logic k);
    if (c < 20) return m[c];
    if (c == 21) return pc_i;
    if (is_priv(c) && k) return m[c];
    return 32'h0;
  endfunction

  function automatic string req_of(input int c);
    if (c < 20) return "R1";
    if (c == 20) return "R2";
    if (c == 21) return "R3";
    if (c < 24) return "R4";
    return "R5";
  endfunction

  task automatic do_write(input int c, input logic [1:0] mode, input logic [31:0] d, input logic k);
    logic [31:0] nv;
    @(negedge clk);
    ra_en = 1'b0; rb_en = 1'b0;
    kernel_i = k; wr_en = 1'b1; wr_addr = 5'(c); wr_mode = mode; wr_data = d;
    #1;
    ck(c == 20 ? "R2" : "R9", {31'h0, fault_o}, {31'h0, wfault(c, k)});
    case (mode)
      2'b01:   nv = {16'h0, d[15:0]};
      2'b10:   nv = {d[15:0], m[c][15:0]};
      default: nv = d;
    endcase
    @(posedge clk);
    if (!wfault(c, k) && c != 20) m[c] = nv;
  endtask

  task automatic read_all(input logic k);
    for (int c = 0; c < 32; c++) begin
      @(negedge clk);
      wr_en = 1'b0; kernel_i = k;
      ra_en = 1'b1; rb_en = 1'b1; ra_addr = 5'(c); rb_addr = 5'(31 - c);
      #1;
      ck(req_of(c), ra_data, mread(c, k));
      ck(req_of(31 - c), rb_data, mread(31 - c, k));
      ck("R9", {31'h0, fault_o}, {31'h0, rfault(c, k) | rfault(31 - c, k)});
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11: everything cleared after reset
    read_all(1'b1);

    // R1 R2 R3 R4 R5 R8: full writes to every code, both full encodings
    for (int s = 0; s < 3; s++) begin
      pc_i = 32'h0000_2000 + 32'(s * 4);
      for (int c = 0; c < 32; c++)
        do_write(c, (c % 2) ? 2'b11 : 2'b00, (32'h9E37_79B9 * 32'(c + 1)) ^ (32'h0F0F_0F0F * 32'(s)), 1'b1);
      read_all(1'b1);
      read_all(1'b0);
    end

    // R4: user-mode writes to privileged codes are ignored
    do_write(22, 2'b00, 32'hDEAD_BEEF, 1'b0);
    do_write(23, 2'b01, 32'h0000_1234, 1'b0);
    read_all(1'b1);

    // R6 R7: split immediate loads, both orders
    for (int c = 0; c < 24; c++) begin
      do_write(c, 2'b01, 32'hFFFF_0000 | 32'(c * 257), 1'b1);
      do_write(c, 2'b10, 32'h5555_0000 | 32'(c * 113), 1'b1);
    end
    read_all(1'b1);
    for (int c = 0; c < 20; c += 3) begin
      do_write(c, 2'b10, 32'h0000_ABCD, 1'b1);
      do_write(c, 2'b01, 32'h7777_4321, 1'b1);
    end
    read_all(1'b1);

    // R10: same-cycle read of written code sees the old value
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      kernel_i = 1'b1; ra_en = 1'b1; rb_en = 1'b0; ra_addr = 5'(c);
      wr_en = 1'b1; wr_addr = 5'(c); wr_mode = 2'b00; wr_data = 32'hC0DE_0000 | 32'(c);
      #1;
      ck("R10", ra_data, m[c]);
      @(posedge clk);
      m[c] = 32'hC0DE_0000 | 32'(c);
      #1;
      ck("R10", ra_data, m[c]);
    end

    // R9: illegal write alongside a legal read; disabled read of bad code
    @(negedge clk);
    kernel_i = 1'b0; ra_en = 1'b1; ra_addr = 5'd3; rb_en = 1'b0; rb_addr = 5'd30;
    wr_en = 1'b1; wr_addr = 5'd21; wr_mode = 2'b00; wr_data = 32'h1111_2222;
    #1;
    ck("R9", {31'h0, fault_o}, 32'h1);
    ck("R3", ra_data, m[3]);
    @(negedge clk);
    wr_en = 1'b0; ra_addr = 5'd22; ra_en = 1'b0;
    #1;
    ck("R9", {31'h0, fault_o}, 32'h0);
    read_all(1'b1);

    // R11: second reset clears all stored state
    @(negedge clk) rst_n = 1'b0;
    for (int i = 0; i < 32; i++) m[i] = 32'h0;
    @(negedge clk) rst_n = 1'b1;
    read_all(1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule